// File: doc/BRIEF.md
# Gated Retriggerable One-Shot

A clocked pulse stretcher with two gating trigger inputs (one active-low, one active-high) and an active-low clear. A qualifying edge on the gates, or a release of the clear while both gates are enabling, starts an output pulse. The pulse is held for a number of clock cycles taken from a duration input. A further qualifying edge during the pulse restarts the full interval, so the pulse can be stretched without limit. Holding the clear low ends any pulse and blocks all triggering.

All three control inputs are asynchronous to the clock. Each passes through a two-flop synchronizer, and edges are found by comparing the synchronized sample with the one before it. The output is registered and comes with its complement. A dual device is two instances.

Top module: `oneshot_pulse`

## Requirements
- R1: A rising edge on `gate_hi` while `gate_lo_n` is low starts a pulse.
- R2: A falling edge on `gate_lo_n` while `gate_hi` is high starts a pulse.
- R3: A rising edge on `clear_n` while `gate_lo_n` is low and `gate_hi` is high starts a pulse.
- R4: A trigger during a pulse reloads the interval. A single retrigger issued `t` cycles after the first trigger gives a high time of `t + width` cycles.
- R5: Driving `clear_n` low ends a pulse in progress. `q` falls on the third rising clock edge after the change.
- R6: While `clear_n` is low, no edge on `gate_lo_n` or `gate_hi` starts a pulse.
- R7: Steady levels, a falling edge on `gate_hi`, a rising edge on `gate_lo_n`, a falling `gate_lo_n` with `gate_hi` low, and a rising `clear_n` without both gates enabling never start a pulse.
- R8: During and after reset `q` is 0 and `q_n` is 1, and `q_n` is the complement of `q` on every cycle.
- R9: `q` rises on the third rising clock edge after a qualifying input change. It stays high for exactly `width` cycles. `width` is sampled on the clock edge that loads the counter, and later changes do not alter the pulse.
- R10: A trigger with `width` equal to 0 produces no pulse.
- R11: A rising `clear_n` and a rising `gate_hi` in the same cycle count as one trigger and give one pulse of `width` cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| gate_lo_n | input | 1 | Active-low trigger gate (asynchronous) |
| gate_hi | input | 1 | Active-high trigger gate (asynchronous) |
| clear_n | input | 1 | Active-low clear; its rising edge can also trigger (asynchronous) |
| width | input | W | Pulse length in clock cycles |
| q | output | 1 | Pulse output |
| q_n | output | 1 | Complement of `q` |

## Verification
The assertions check on every cycle the cycle-level relationships:
- a synchronized low clear forces `q` low on the next edge;
- `q` cannot rise without a detected trigger;
- a trigger with a nonzero length raises `q` on the next edge;
- a zero length keeps `q` low;
- `q` only falls when the counter expires, when the clear is applied, or when a zero-length trigger arrives.

Only the bench scenarios can show the following:
- which input edge combinations qualify as triggers;
- the three-edge input latency;
- the exact pulse widths, including stretching by a retrigger;
- that a length change after loading has no effect;
- that coincident triggers yield a single pulse.

// File: rtl/oneshot_pulse.sv
module oneshot_pulse #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         gate_lo_n,
  input  logic         gate_hi,
  input  logic         clear_n,
  input  logic [W-1:0] width,
  output logic         q,
  output logic         q_n
);

  // [0] first sync flop, [1] synchronized level, [2] previous synchronized level
  logic [2:0] a_sr, b_sr, c_sr;
  logic [W-1:0] cnt, cnt_nxt;
  logic a_s, a_p, b_s, b_p, c_s, c_p;
  logic trig;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      a_sr <= '1;
      b_sr <= '0;
      c_sr <= '1;
    end else begin
      a_sr <= {a_sr[1:0], gate_lo_n};
      b_sr <= {b_sr[1:0], gate_hi};
      c_sr <= {c_sr[1:0], clear_n};
    end
  end

  assign a_s = a_sr[1];
  assign a_p = a_sr[2];
  assign b_s = b_sr[1];
  assign b_p = b_sr[2];
  assign c_s = c_sr[1];
  assign c_p = c_sr[2];

  assign trig = c_s & ( (b_s & ~b_p & ~a_s)
                      | (~a_s & a_p & b_s)
                      | (~c_p & ~a_s & b_s) );

  always_comb begin
    if (!c_s)             cnt_nxt = '0;
    else if (trig)        cnt_nxt = width;
    else if (cnt != '0)   cnt_nxt = cnt - 1'b1;
    else                  cnt_nxt = cnt;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
      q   <= 1'b0;
    end else begin
      cnt <= cnt_nxt;
      q   <= (cnt_nxt != '0);
    end
  end

  assign q_n = ~q;

endmodule

// File: rtl/oneshot_pulse_chk.sv
module oneshot_pulse_chk #(
  parameter int W = 8
) (
  input logic         clk,
  input logic         rst_n,
  input logic         q,
  input logic [W-1:0] width,
  input logic         trig,
  input logic         c_s,
  input logic [W-1:0] cnt
);

  a_r5_clear_drops_q: assert property (@(posedge clk) disable iff (!rst_n)
    !c_s |=> !q);

  a_r7_no_spurious_start: assert property (@(posedge clk) disable iff (!rst_n)
    (!q && !trig) |=> !q);

  a_r4_trigger_raises_q: assert property (@(posedge clk) disable iff (!rst_n)
    (trig && c_s && width != '0) |=> q);

  a_r10_zero_width_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (trig && width == '0) |=> !q);

  a_r9_fall_reason: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(q) |-> ($past(cnt) == 1 || !$past(c_s) || $past(trig)));

endmodule

bind oneshot_pulse oneshot_pulse_chk #(.W(W)) chk_i (
  .clk(clk), .rst_n(rst_n), .q(q), .width(width),
  .trig(trig), .c_s(c_s), .cnt(cnt)
);

// File: tb/oneshot_pulse_tb_top.sv
`timescale 1ns/100ps
module oneshot_pulse_tb_top;

  typedef struct {
    bit    v;
    string r;
  } exp_t;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       a_n = 1'b1, b = 1'b0, c = 1'b1;
  logic [7:0] d = 8'd5;
  logic       q, q_n;

  int   n_chk = 0, n_bad = 0;
  bit   done = 1'b0;
  exp_t sb[$];

  always #2.5 clk = ~clk;

  oneshot_pulse #(.W(8)) dut_i (
    .clk(clk), .rst_n(rst_n), .gate_lo_n(a_n), .gate_hi(b),
    .clear_n(c), .width(d), .q(q), .q_n(q_n)
  );

  always @(negedge clk) begin
    if (sb.size() > 0) begin
      exp_t e;
      e = sb.pop_front();
      n_chk++;
      if (q !== e.v || q_n !== ~e.v) begin
        n_bad++;
        $display("FAIL %s: q=%b q_n=%b expected q=%b q_n=%b at %0t",
                 e.r, q, q_n, e.v, ~e.v, $time);
      end
    end
  end

  task automatic push(bit v, string r);
    exp_t e;
    e.v = v;
    e.r = r;
    sb.push_back(e);
  endtask

  task automatic step(logic na, logic nb, logic nc, logic [7:0] nd, bit v, string r);
    @(negedge clk);
    #1;
    a_n = na; b = nb; c = nc; d = nd;
    push(v, r);
  endtask

  task automatic run(int n, bit v, string r);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      #1;
      push(v, r);
    end
  endtask

  task automatic finish_run();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    #(200000 * 5);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: run did not end, actual=hung expected=done");
    finish_run();
  end

  initial begin
    repeat (4) @(negedge clk);
    n_chk++;
    if (q !== 1'b0 || q_n !== 1'b1) begin
      n_bad++;
      $display("FAIL R8: in reset q=%b q_n=%b expected 0/1", q, q_n);
    end
    rst_n = 1'b1;
    run(3, 0, "R8");

    step(0, 0, 1, 5, 0, "R7"); run(5, 0, "R7");

    step(0, 1, 1, 5, 0, "R1"); run(1, 0, "R1"); run(5, 1, "R1"); run(3, 0, "R1");

    step(1, 1, 1, 5, 0, "R7"); run(4, 0, "R7");

    step(0, 1, 1, 5, 0, "R2"); run(1, 0, "R2"); run(5, 1, "R2"); run(3, 0, "R2");

    step(0, 1, 0, 5, 0, "R3"); run(3, 0, "R3");
    step(0, 1, 1, 5, 0, "R3"); run(1, 0, "R3"); run(5, 1, "R3"); run(3, 0, "R3");

    step(0, 0, 1, 5, 0, "R4"); run(3, 0, "R4");
    step(0, 1, 1, 5, 0, "R4"); run(1, 0, "R4"); run(1, 1, "R4");
    step(0, 0, 1, 5, 1, "R4"); step(0, 1, 1, 5, 1, "R4");
    run(6, 1, "R4"); run(3, 0, "R4");

    step(0, 0, 1, 5, 0, "R5"); run(3, 0, "R5");
    step(0, 1, 1, 5, 0, "R5"); run(1, 0, "R5"); run(1, 1, "R5");
    step(0, 1, 0, 5, 1, "R5"); run(1, 1, "R5"); run(3, 0, "R5");

    step(0, 0, 0, 5, 0, "R6"); run(2, 0, "R6");
    step(0, 1, 0, 5, 0, "R6"); run(4, 0, "R6");
    step(1, 1, 0, 5, 0, "R6"); step(0, 1, 0, 5, 0, "R6"); run(4, 0, "R6");
    step(0, 0, 0, 5, 0, "R7"); run(2, 0, "R7");
    step(0, 0, 1, 5, 0, "R7"); run(4, 0, "R7");

    step(0, 1, 1, 5, 0, "R9"); run(1, 0, "R9"); run(1, 1, "R9");
    step(0, 1, 1, 2, 1, "R9"); run(3, 1, "R9"); run(3, 0, "R9");

    step(0, 0, 1, 0, 0, "R10"); run(3, 0, "R10");
    step(0, 1, 1, 0, 0, "R10"); run(6, 0, "R10");

    step(0, 0, 1, 1, 0, "R9"); run(3, 0, "R9");
    step(0, 1, 1, 1, 0, "R9"); run(1, 0, "R9"); run(1, 1, "R9"); run(3, 0, "R9");

    step(0, 0, 0, 3, 0, "R11"); run(3, 0, "R11");
    step(0, 1, 1, 3, 0, "R11"); run(1, 0, "R11"); run(3, 1, "R11"); run(4, 0, "R11");

    while (sb.size() > 0) @(negedge clk);
    @(negedge clk);
    done = 1'b1;
    finish_run();
  end

endmodule